// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Sequencer

This block programs a user-programmable frequency synthesizer over that part's two-wire interface. The interface has a serial clock pin and a serial data pin. A request carries five fields: a multiplier, a divider, a post-divisor code, a target clock slot and a register number. On acceptance the block checks the multiplier and divider ranges. It packs the fields into a 24-bit command word. It then plays the whole pin sequence, one step at a time: an unlock preamble, a start pattern, the 24 word bits sent least significant first, and a closing stop pattern.

Each pin step is held for a fixed number of system clocks, set by the `STEP_CLKS` parameter. Both pins are driven from flops, so they do not glitch between steps. A request with a multiplier or divider out of range is refused with a one-cycle error pulse, and the pins are never touched for it.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset, and whenever the block is idle, the pins sit at clk=0 and data=0. In that state `req_ready` is 1, `busy` is 0 and `done` is 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. While a sequence runs, `req_ready` is 0, and any request or field change has no effect on the word being sent.
- R3: If the multiplier is outside 3..130 or the divider is outside 2..129, the block raises `err` for exactly the one cycle after acceptance. It stays idle, and the pins remain at (0,0).
- R4: The command word is laid out as follows. Bits 7:1 hold divider-2. Bits 9:8 hold the post-divisor code (0=÷1, 1=÷2, 2=÷4, 3=÷8). Bits 17:11 hold multiplier-3. Bits 21:18 hold the clock slot. Bits 23:22 hold the register number. Bits 0 and 10 are 0.
- R5: The word bits are sent in order from bit 0 up to bit 23.
- R6: The preamble is 14 steps, given as (clk,data): (0,0), (0,1), then (1,1),(0,1) repeated six times.
- R7: The start pattern follows the preamble as four steps: (0,0),(1,0),(0,0),(1,0).
- R8: Each word bit d takes four steps: (1,~d),(0,~d),(0,d),(1,d).
- R9: The stop pattern follows the last bit as three steps: (1,1),(0,1),(1,1).
- R10: Every step holds its pin values for exactly `STEP_CLKS` system clocks. A full sequence is 117 steps long.
- R11: In the cycle after the final stop step ends, `done` is 1 for exactly one cycle. In that same cycle the pins return to (0,0) and `req_ready` goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mul | input | 8 | Multiplier value (legal 3..130) |
| req_div | input | 8 | Divider value (legal 2..129) |
| req_post | input | 2 | Post-divisor code |
| req_slot | input | 4 | Target clock slot |
| req_regno | input | 2 | Target register number |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle range-error pulse |
| prog_clk | output | 1 | Serial clock pin to the synthesizer |
| prog_data | output | 1 | Serial data pin to the synthesizer |

## Verification
The bench targets the range edges (multiplier 2/3/130/131 and divider 1/2/129/130). An off-by-one in the check there would either push an illegal word onto the pins or refuse a legal one. Every data bit is decoded back from its four steps, and the inverse and true halves are checked to be complementary. This catches a bit order reversed to MSB-first, a swapped phase or a wrong field offset, because each of these produces a decoded word that differs from the arithmetic expectation. Each step is sampled on every one of its cycles, which exposes a step that is too short or too long. A request held up during a transfer, with altered fields, would show up as a corrupted word if the handshake leaked.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W    = 24;
  localparam int PRE_LEN   = 14;
  localparam int START_LEN = 4;
  localparam int BIT_STEPS = 4;
  localparam int DATA_LEN  = WORD_W * BIT_STEPS;
  localparam int STOP_LEN  = 3;
  localparam int START_AT  = PRE_LEN;
  localparam int DATA_AT   = START_AT + START_LEN;
  localparam int STOP_AT   = DATA_AT + DATA_LEN;
  localparam int TOTAL     = STOP_AT + STOP_LEN;
  localparam int STEP_W    = $clog2(TOTAL);

  typedef struct packed {
    logic [7:0] mul;
    logic [7:0] div;
    logic [1:0] post;
    logic [3:0] slot;
    logic [1:0] regno;
  } synth_req_t;
endpackage

// File: rtl/synth_word_pack.sv
module synth_word_pack
  import synth_prog_pkg::*;
(
  input  synth_req_t        req,
  output logic [WORD_W-1:0] word,
  output logic              legal
);
  logic mul_ok, div_ok;

  assign mul_ok = (req.mul >= 8'd3) && (req.mul <= 8'd130);
  assign div_ok = (req.div >= 8'd2) && (req.div <= 8'd129);
  assign legal  = mul_ok && div_ok;

  assign word[0]     = 1'b0;
  assign word[7:1]   = 7'(req.div - 8'd2);
  assign word[9:8]   = req.post;
  assign word[10]    = 1'b0;
  assign word[17:11] = 7'(req.mul - 8'd3);
  assign word[21:18] = req.slot;
  assign word[23:22] = req.regno;
endmodule

// File: rtl/step_pacer.sv
module step_pacer #(
  parameter int STEP_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/pin_pattern.sv
module pin_pattern
  import synth_prog_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [WORD_W-1:0] word,
  output logic              pclk,
  output logic              pdata
);
  int unsigned s, j;
  logic        d;

  always_comb begin
    s     = 32'(step);
    j     = 0;
    d     = 1'b0;
    pclk  = 1'b0;
    pdata = 1'b0;
    if (s < 2) begin
      pdata = (s == 1);
    end else if (s < START_AT) begin
      j     = s - 2;
      pclk  = (j % 2 == 0);
      pdata = 1'b1;
    end else if (s < DATA_AT) begin
      j     = s - START_AT;
      pclk  = (j % 2 == 1);
    end else if (s < STOP_AT) begin
      j     = s - DATA_AT;
      d     = word[j / BIT_STEPS];
      case (j % BIT_STEPS)
        0:       begin pclk = 1'b1; pdata = ~d; end
        1:       begin pclk = 1'b0; pdata = ~d; end
        2:       begin pclk = 1'b0; pdata = d;  end
        default: begin pclk = 1'b1; pdata = d;  end
      endcase
    end else begin
      j     = s - STOP_AT;
      pclk  = (j != 1);
      pdata = 1'b1;
    end
  end
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int STEP_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_mul,
  input  logic [7:0] req_div,
  input  logic [1:0] req_post,
  input  logic [3:0] req_slot,
  input  logic [1:0] req_regno,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       prog_clk,
  output logic       prog_data
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);

  synth_req_t        req;
  logic [WORD_W-1:0] new_word, word_q, pat_word;
  logic              legal, tick, pat_clk, pat_data;
  logic              busy_q, done_q, err_q, clk_q, data_q;
  logic [STEP_W-1:0] step_q, pat_step;
  logic              take;

  assign req = '{mul: req_mul, div: req_div, post: req_post,
                 slot: req_slot, regno: req_regno};

  synth_word_pack u_pack (.req(req), .word(new_word), .legal(legal));

  step_pacer #(.STEP_CLKS(STEP_CLKS)) u_pace (
    .clk(clk), .rst(rst), .run(busy_q), .tick(tick));

  assign pat_step = busy_q ? step_q + 1'b1 : '0;
  assign pat_word = busy_q ? word_q : new_word;

  pin_pattern u_pat (.step(pat_step), .word(pat_word),
                     .pclk(pat_clk), .pdata(pat_data));

  assign take = req_valid && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      clk_q  <= 1'b0; data_q <= 1'b0;
      step_q <= '0;   word_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (take) begin
        if (legal) begin
          busy_q <= 1'b1;
          step_q <= '0;
          word_q <= new_word;
          clk_q  <= pat_clk;
          data_q <= pat_data;
        end else begin
          err_q  <= 1'b1;
        end
      end else if (tick) begin
        if (step_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          clk_q  <= 1'b0;
          data_q <= 1'b0;
        end else begin
          step_q <= step_q + 1'b1;
          clk_q  <= pat_clk;
          data_q <= pat_data;
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign prog_clk  = clk_q;
  assign prog_data = data_q;

  // R1
  idle_park_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!clk_q && !data_q));
  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (!busy_q || $stable(word_q)));
  // R3
  bad_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !legal) |=> (err && !busy && !prog_clk && !prog_data));
  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // R10
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick) |=> $stable({clk_q, data_q}));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !prog_clk && !prog_data));
endmodule

// File: tb/sim_synth_prog_seq.sv
module sim_synth_prog_seq;
  localparam int S     = 2;
  localparam int STEPS = 117;

  logic       clk = 1'b0, rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready, busy, done, err, prog_clk, prog_data;
  logic [7:0] req_mul = 8'd0, req_div = 8'd0;
  logic [1:0] req_post = 2'd0, req_regno = 2'd0;
  logic [3:0] req_slot = 4'd0;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;
  logic [1:0] seq [STEPS];

  always #2.5 clk = ~clk;

  synth_prog_seq #(.STEP_CLKS(S)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mul(req_mul), .req_div(req_div), .req_post(req_post),
    .req_slot(req_slot), .req_regno(req_regno), .busy(busy), .done(done),
    .err(err), .prog_clk(prog_clk), .prog_data(prog_data));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_word(int m, int d, int p, int sl, int rg);
    return rg * (1 << 22) + sl * (1 << 18) + (m - 3) * (1 << 11)
         + p * (1 << 8) + (d - 2) * 2;
  endfunction

  task automatic run_good(input int m, input int d, input int p,
                          input int sl, input int rg, input bit poke);
    int word;
    int exp_w;
    @(negedge clk);
    req_valid = 1'b1; req_mul = 8'(m); req_div = 8'(d);
    req_post = 2'(p); req_slot = 4'(sl); req_regno = 2'(rg);
    chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < STEPS; k++) begin
      for (int c = 0; c < S; c++) begin
        if (poke && k == 40) begin
          req_valid = 1'b1; req_mul = 8'd99; req_div = 8'd77;
          req_slot = 4'hF; req_regno = 2'd3;
          chk(req_ready == 1'b0, "R2 ready low while busy", int'(req_ready), 0);
        end
        if (poke && k == 45) req_valid = 1'b0;
        if (c == 0) seq[k] = {prog_clk, prog_data};
        else chk({prog_clk, prog_data} == seq[k], "R10 step hold",
                 int'({prog_clk, prog_data}), int'(seq[k]));
        @(negedge clk);
      end
    end
    chk(done == 1'b1, "R11 done after stop", int'(done), 1);
    chk({prog_clk, prog_data, req_ready} == 3'b001, "R11 park and ready",
        int'({prog_clk, prog_data, req_ready}), 1);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", int'(done), 0);
    chk(seq[0] == 2'b00 && seq[1] == 2'b01, "R6 preamble head",
        int'({seq[0], seq[1]}), 1);
    for (int j = 0; j < 12; j++)
      chk(seq[2 + j] == ((j % 2 == 0) ? 2'b11 : 2'b01), "R6 preamble pulse",
          int'(seq[2 + j]), (j % 2 == 0) ? 3 : 1);
    for (int j = 0; j < 4; j++)
      chk(seq[14 + j] == ((j % 2 == 1) ? 2'b10 : 2'b00), "R7 start pattern",
          int'(seq[14 + j]), (j % 2 == 1) ? 2 : 0);
    word = 0;
    for (int b = 0; b < 24; b++) begin
      logic [1:0] p0, p1, p2, p3;
      p0 = seq[18 + 4*b]; p1 = seq[19 + 4*b];
      p2 = seq[20 + 4*b]; p3 = seq[21 + 4*b];
      chk(p0[1] == 1'b1 && p1[1] == 1'b0 && p2[1] == 1'b0 && p3[1] == 1'b1,
          "R8 bit clock shape", int'({p0[1], p1[1], p2[1], p3[1]}), 9);
      chk(p0[0] == p1[0] && p2[0] == p3[0] && p0[0] != p2[0],
          "R8 inverse/true phases", int'({p0[0], p1[0], p2[0], p3[0]}), 3);
      if (p3[0]) word = word | (1 << b);
    end
    exp_w = exp_word(m, d, p, sl, rg);
    chk(word == exp_w, "R4 R5 decoded word", word, exp_w);
    chk(seq[114] == 2'b11 && seq[115] == 2'b01 && seq[116] == 2'b11,
        "R9 stop pattern", int'({seq[114], seq[115], seq[116]}), 6'h37);
  endtask

  task automatic run_bad(input int m, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_mul = 8'(m); req_div = 8'(d);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R3 error pulse", int'({err, busy}), 2);
    chk({prog_clk, prog_data} == 2'b00, "R3 pins untouched",
        int'({prog_clk, prog_data}), 0);
    @(negedge clk);
    chk(err == 1'b0 && req_ready == 1'b1, "R3 error single cycle",
        int'({err, req_ready}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({prog_clk, prog_data, busy, done, err} == 5'b0, "R1 reset state",
        int'({prog_clk, prog_data, busy, done, err}), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    for (int p = 0; p < 4; p++) begin
      run_good(3, 2, p, p * 4 + 1, p, 1'b0);
      run_good(130, 129, p, 15 - p, 3 - p, 1'b0);
    end
    run_good(77, 50, 2, 10, 2, 1'b1);
    run_good(64, 100, 1, 5, 1, 1'b0);
    for (int s = 0; s < 16; s++) run_good(3 + s * 8, 129 - s * 8, s % 4, s, s % 4, 1'b0);
    run_bad(2, 50);
    run_bad(131, 50);
    run_bad(0, 2);
    run_bad(255, 129);
    run_bad(64, 1);
    run_bad(64, 130);
    run_good(130, 2, 3, 9, 0, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule